// File: doc/BRIEF.md
# Dual-Capture Timer Pair with Power-of-Two Prescaler

This block holds two identical timer channels. Each channel has a counter that counts up. The counter steps once each time a programmable power-of-two prescaler wraps. Each channel has two capture pins, A and B. A pin passes through a two-flop synchronizer, and its selected edge copies the running count into a capture register for that pin. Software can therefore measure a signal's period with one capture and its high or low time with the other. A setting per channel routes pin A to both capture paths. Each path keeps its own edge choice, so the period and duty cycle of one signal can be measured using a single pin.

A configuration word is written per channel. It sets the prescaler exponent, the two edge selects and the routing bit. It also carries two write-one strobes that drive the channel's output pin high or low. One control word is shared by both channels. It holds a restart bit per channel, which clears that counter and its prescaler, so one write brings both channels into step. It also holds an interrupt-enable bit per channel. Sticky flags record capture A, capture B and counter wrap. Software clears them by writing ones. The interrupt of a channel is the OR of its flags, gated by its enable bit.

Top module: `tmr_dual_capture`

## Requirements
- R1: With exponent field cfg bits [3:0] = N, the counter advances once every 2^N clocks after a restart. The first step comes 2^N clocks after the restart write. N=0 counts every clock and N=15 every 32768 clocks.
- R2: Each capture path has a 2-bit edge select. 00 reacts to falling edges, 01 to rising edges, and 10 and 11 to both edges. Pin B's select is cfg bits [8:7] and pin A's is cfg bits [10:9].
- R3: A pin change driven before clock edge k is captured at edge k+2. The capture register then holds the count present between edges k+1 and k+2, and the sticky flag for that path is set. Flag bits are 0 = capture A, 1 = capture B, 2 = wrap.
- R4: With cfg bit 6 set, both capture paths are fed from pin A, each through its own edge select, and activity on pin B has no effect.
- R5: Writing cfg with bit 4 set drives the output pin high from the next clock. A cfg write with bit 4 clear leaves the pin unchanged. Bits 4 and 5 always read back as 0.
- R6: Writing cfg with bit 5 set drives the output pin low from the next clock. When bits 4 and 5 are both set in one write, the pin goes low.
- R7: Control bit i (i = 0,1) restarts channel i by clearing its count and its prescaler. Channels restarted in the same write stay in step afterwards.
- R8: Control bit 2+i enables the interrupt of channel i. The interrupt is high exactly when that enable is set and at least one flag is set.
- R9: When the counter steps from all ones to zero, the wrap flag is set. A write of ones to the flag-clear port clears only the flags selected by those bits.
- R10: After reset, counts, captures, flags, output pins and interrupts are all zero, and the counters run at a divide ratio of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | NT | Per-channel configuration write strobe |
| cfg_wdata | input | 11 | Configuration word (shared data) |
| ctl_wr | input | 1 | Shared control write strobe |
| ctl_wdata | input | 2*NT | Restart bits [NT-1:0], interrupt enables [2*NT-1:NT] |
| flg_clr_wr | input | NT | Per-channel flag-clear strobe |
| flg_clr_data | input | 3 | Flags to clear (one bit per flag) |
| cap_a | input | NT | Capture pin A per channel (asynchronous) |
| cap_b | input | NT | Capture pin B per channel (asynchronous) |
| cnt_o | output | NT*CNT_W | Running counts |
| capa_o | output | NT*CNT_W | Capture A registers |
| capb_o | output | NT*CNT_W | Capture B registers |
| flags_o | output | NT*3 | Sticky flags per channel |
| cfg_rd_o | output | NT*11 | Configuration read-back |
| tout_o | output | NT | Timer output pins |
| irq_o | output | NT | Interrupt requests |

## Verification
The bench uses the default build: two channels and a 16-bit counter. With this width, a full wrap from all ones to zero takes 65536 clocks at a divide ratio of 1, so the bench reaches it directly. The same run also covers the slowest prescaler setting of 32768. The second channel is present, so the shared restart write can be shown to re-align two counters that were out of phase.

// File: rtl/tmr_pkg.sv
// Package: shared field positions, flag indices and edge-select type for the
// dual-capture timer. Assumes an 11-bit configuration word per channel.
package tmr_pkg;
    localparam int PS_W      = 4;   // prescaler exponent width
    localparam int CFG_W     = 11;  // configuration word width
    localparam int CFG_PS    = 0;   // exponent LSB
    localparam int CFG_SET   = 4;   // output-high strobe
    localparam int CFG_CLR   = 5;   // output-low strobe
    localparam int CFG_TIE   = 6;   // route pin A to both paths
    localparam int CFG_EB    = 7;   // pin B edge select LSB
    localparam int CFG_EA    = 9;   // pin A edge select LSB
    localparam int FLG_W     = 3;
    localparam int FLG_CAPA  = 0;
    localparam int FLG_CAPB  = 1;
    localparam int FLG_WRAP  = 2;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_BOTH2 = 2'b11
    } edge_sel_e;

    // Qualify a synchronized level change against the chosen edge kind.
    function automatic logic edge_hit(input logic cur, input logic prev, input edge_sel_e sel);
        case (sel)
            EDGE_FALL: edge_hit = prev & ~cur;
            EDGE_RISE: edge_hit = ~prev & cur;
            default:   edge_hit = prev ^ cur;
        endcase
    endfunction
endpackage

// File: rtl/tmr_sync.sv
// Module: two-flop synchronizer with one extra history stage, giving the
// current and previous synchronized levels of an asynchronous pin.
// Assumes the pin idles low at reset.
module tmr_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic cur,
    output logic prev
);
    logic meta;

    // Shift the pin through two sync flops and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            cur  <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= din;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Module: power-of-two prescaler. Emits one tick every 2^exp clocks,
// restarting from zero on clr. A lowered exponent takes effect at once.
module tmr_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PS_W-1:0] exp_i,
    output logic            tick
);
    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] mask;

    // Terminal value is 2^exp - 1; the tick fires on reaching it.
    always_comb begin
        mask = ~({PC_W{1'b1}} << exp_i);
        tick = (pcnt >= mask) && !clr;
    end

    // Advance the prescaler count, wrapping on tick or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) pcnt <= '0;
        else                        pcnt <= pcnt + 1'b1;
    end

    a_r7_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/tmr_channel.sv
// Module: one timer channel: config register, prescaler, counter, two
// capture paths, sticky flags, output pin and gated interrupt.
// Assumes write strobes are single-cycle and capture pins are asynchronous.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             restart,
    input  logic             irq_en,
    input  logic             flg_clr_wr,
    input  logic [FLG_W-1:0] flg_clr_data,
    input  logic             pin_a,
    input  logic             pin_b,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_a_q,
    output logic [CNT_W-1:0] cap_b_q,
    output logic [FLG_W-1:0] flags,
    output logic [CFG_W-1:0] cfg_rd,
    output logic             tout,
    output logic             irq
);
    logic [PS_W-1:0] ps_q;
    logic            tie_q;
    edge_sel_e       sel_a_q, sel_b_q;
    logic            tick;
    logic            a_cur, a_prev, b_cur, b_prev;
    logic            hit_a, hit_b, wrap;
    logic [FLG_W-1:0] set_vec, clr_vec;

    // Hold the persistent configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= '0;
            tie_q   <= 1'b0;
            sel_a_q <= EDGE_FALL;
            sel_b_q <= EDGE_FALL;
        end else if (cfg_wr) begin
            ps_q    <= cfg_wdata[CFG_PS +: PS_W];
            tie_q   <= cfg_wdata[CFG_TIE];
            sel_a_q <= edge_sel_e'(cfg_wdata[CFG_EA +: 2]);
            sel_b_q <= edge_sel_e'(cfg_wdata[CFG_EB +: 2]);
        end
    end

    // Read-back: strobe bits always return zero.
    always_comb begin
        cfg_rd = '0;
        cfg_rd[CFG_PS +: PS_W] = ps_q;
        cfg_rd[CFG_TIE]        = tie_q;
        cfg_rd[CFG_EA +: 2]    = sel_a_q;
        cfg_rd[CFG_EB +: 2]    = sel_b_q;
    end

    tmr_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(restart), .exp_i(ps_q), .tick(tick)
    );

    tmr_sync u_sync_a (.clk(clk), .rst_n(rst_n), .din(pin_a), .cur(a_cur), .prev(a_prev));
    tmr_sync u_sync_b (.clk(clk), .rst_n(rst_n), .din(pin_b), .cur(b_cur), .prev(b_prev));

    // Edge qualification; path B borrows pin A when tied.
    always_comb begin
        hit_a = edge_hit(a_cur, a_prev, sel_a_q);
        hit_b = tie_q ? edge_hit(a_cur, a_prev, sel_b_q)
                      : edge_hit(b_cur, b_prev, sel_b_q);
        wrap  = tick && (count == '1);
    end

    // Main counter: restart has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) count <= '0;
        else if (tick)         count <= count + 1'b1;
    end

    // Capture registers load the running count on a qualified edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a_q <= '0;
            cap_b_q <= '0;
        end else begin
            if (hit_a) cap_a_q <= count;
            if (hit_b) cap_b_q <= count;
        end
    end

    // Sticky flags: new events win over a same-cycle clear.
    always_comb begin
        set_vec = '0;
        set_vec[FLG_CAPA] = hit_a;
        set_vec[FLG_CAPB] = hit_b;
        set_vec[FLG_WRAP] = wrap && !restart;
        clr_vec = flg_clr_wr ? flg_clr_data : '0;
    end

    // Update the flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_vec) | set_vec;
    end

    // Output pin: low strobe wins over high strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) tout <= 1'b0;
        else if (cfg_wr && cfg_wdata[CFG_CLR]) tout <= 1'b0;
        else if (cfg_wr && cfg_wdata[CFG_SET]) tout <= 1'b1;
    end

    assign irq = irq_en && (flags != '0);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));
    a_r3_capture_a: assert property (@(posedge clk) disable iff (!rst_n)
        hit_a |=> (cap_a_q == $past(count)) && flags[FLG_CAPA]);
    a_r3_capture_b: assert property (@(posedge clk) disable iff (!rst_n)
        hit_b |=> (cap_b_q == $past(count)) && flags[FLG_CAPB]);
    a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !restart) |=> flags[FLG_WRAP] && (count == '0));
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[CFG_SET] && !cfg_wdata[CFG_CLR]) |=> tout);
    a_r6_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[CFG_CLR]) |=> !tout);
endmodule

// File: rtl/tmr_dual_capture.sv
// Module: top of the dual-capture timer pair. Holds the shared control word
// (per-channel restart strobes and interrupt enables) and one channel per
// timer. Assumes one write per port per cycle.
module tmr_dual_capture
    import tmr_pkg::*;
#(
    parameter int NT    = 2,
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT-1:0]       cfg_wr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                ctl_wr,
    input  logic [2*NT-1:0]     ctl_wdata,
    input  logic [NT-1:0]       flg_clr_wr,
    input  logic [FLG_W-1:0]    flg_clr_data,
    input  logic [NT-1:0]       cap_a,
    input  logic [NT-1:0]       cap_b,
    output logic [NT*CNT_W-1:0] cnt_o,
    output logic [NT*CNT_W-1:0] capa_o,
    output logic [NT*CNT_W-1:0] capb_o,
    output logic [NT*FLG_W-1:0] flags_o,
    output logic [NT*CFG_W-1:0] cfg_rd_o,
    output logic [NT-1:0]       tout_o,
    output logic [NT-1:0]       irq_o
);
    logic [NT-1:0] ien_q;
    logic [NT-1:0] restart;

    // Store interrupt enables from the shared control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ctl_wr) ien_q <= ctl_wdata[NT +: NT];
    end

    // Restart bits act only in the cycle of the write.
    assign restart = ctl_wr ? ctl_wdata[NT-1:0] : '0;

    for (genvar i = 0; i < NT; i++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr(cfg_wr[i]), .cfg_wdata(cfg_wdata),
            .restart(restart[i]), .irq_en(ien_q[i]),
            .flg_clr_wr(flg_clr_wr[i]), .flg_clr_data(flg_clr_data),
            .pin_a(cap_a[i]), .pin_b(cap_b[i]),
            .count(cnt_o[i*CNT_W +: CNT_W]),
            .cap_a_q(capa_o[i*CNT_W +: CNT_W]),
            .cap_b_q(capb_o[i*CNT_W +: CNT_W]),
            .flags(flags_o[i*FLG_W +: FLG_W]),
            .cfg_rd(cfg_rd_o[i*CFG_W +: CFG_W]),
            .tout(tout_o[i]), .irq(irq_o[i])
        );
    end

    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !ctl_wdata[NT]) |=> !irq_o[0]);
endmodule

// File: tb/sim_tmr_dual_capture.sv
`timescale 1ns/1ps
module sim_tmr_dual_capture;
    localparam int NT = 2;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] cfg_wr = '0;
    logic [10:0] cfg_wdata = '0;
    logic ctl_wr = 1'b0;
    logic [2*NT-1:0] ctl_wdata = '0;
    logic [NT-1:0] flg_clr_wr = '0;
    logic [2:0] flg_clr_data = '0;
    logic [NT-1:0] cap_a = '0;
    logic [NT-1:0] cap_b = '0;
    logic [NT*CW-1:0] cnt_o, capa_o, capb_o;
    logic [NT*3-1:0] flags_o;
    logic [NT*11-1:0] cfg_rd_o;
    logic [NT-1:0] tout_o, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr_dual_capture #(.NT(NT), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flg_clr_wr(flg_clr_wr),
        .flg_clr_data(flg_clr_data), .cap_a(cap_a), .cap_b(cap_b),
        .cnt_o(cnt_o), .capa_o(capa_o), .capb_o(capb_o), .flags_o(flags_o),
        .cfg_rd_o(cfg_rd_o), .tout_o(tout_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(input logic [3:0] ps, input logic set, input logic clr,
                                      input logic tie, input logic [1:0] eb, input logic [1:0] ea);
        return {ea, eb, tie, clr, set, ps};
    endfunction

    task automatic wr_cfg(input int ch, input logic [10:0] d);
        cfg_wr = '0; cfg_wr[ch] = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = '0;
    endtask

    task automatic wr_ctl(input logic [3:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic clr_flags(input logic [2:0] d);
        flg_clr_wr = 2'b01; flg_clr_data = d;
        @(negedge clk); flg_clr_wr = '0;
    endtask

    // Drive a pin of channel 0 and return the count that must be captured.
    task automatic drive_pin(input bit pin_b, input logic v, output logic [15:0] c);
        if (pin_b) cap_b[0] = v; else cap_a[0] = v;
        @(negedge clk); @(negedge clk);
        c = cnt_o[15:0];
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R10 count", cnt_o[15:0], 16'd0);
        check("R10 flags", flags_o, '0);
        check("R10 tout", tout_o, '0);
        check("R10 irq", irq_o, '0);
        check("R10 caps", capa_o[15:0] | capb_o[15:0], 0);
        @(negedge clk);
        check("R10 runs at ratio 1", cnt_o[15:0], 16'd1);
    endtask

    task automatic t_tout;
        wr_cfg(0, mk(0, 1, 0, 0, 0, 0));
        check("R5 set drives high", tout_o[0], 1'b1);
        check("R5 strobe reads 0", cfg_rd_o[5:4], 2'b00);
        wr_cfg(0, mk(0, 0, 0, 0, 0, 0));
        check("R5 zero write no effect", tout_o[0], 1'b1);
        wr_cfg(0, mk(0, 0, 1, 0, 0, 0));
        check("R6 clr drives low", tout_o[0], 1'b0);
        wr_cfg(0, mk(0, 1, 0, 0, 0, 0));
        wr_cfg(0, mk(0, 1, 1, 0, 0, 0));
        check("R6 clr wins over set", tout_o[0], 1'b0);
    endtask

    task automatic t_presc;
        wr_cfg(0, mk(4'd2, 0, 0, 0, 0, 0));
        wr_ctl(4'b0001);
        repeat (3) @(negedge clk);
        check("R1 div4 before step", cnt_o[15:0], 16'd0);
        @(negedge clk);
        check("R1 div4 first step", cnt_o[15:0], 16'd1);
        repeat (4) @(negedge clk);
        check("R1 div4 second step", cnt_o[15:0], 16'd2);
    endtask

    task automatic t_capture;
        logic [15:0] c;
        wr_cfg(0, mk(0, 0, 0, 0, 2'b00, 2'b01)); // A rising, B falling
        clr_flags(3'b111);
        drive_pin(0, 1'b1, c);
        check("R3 capture A value", capa_o[15:0], c);
        check("R2 rising flag A", flags_o[0], 1'b1);
        clr_flags(3'b001);
        drive_pin(0, 1'b0, c);
        check("R2 rising ignores fall", flags_o[0], 1'b0);
        drive_pin(1, 1'b1, c);
        check("R2 falling ignores rise", flags_o[1], 1'b0);
        drive_pin(1, 1'b0, c);
        check("R3 capture B value", capb_o[15:0], c);
        check("R2 falling flag B", flags_o[1], 1'b1);
    endtask

    task automatic t_any;
        logic [15:0] c;
        wr_cfg(0, mk(0, 0, 0, 0, 2'b11, 2'b10));
        clr_flags(3'b111);
        drive_pin(0, 1'b1, c);
        check("R2 any (10) rise", flags_o[0], 1'b1);
        clr_flags(3'b001);
        drive_pin(0, 1'b0, c);
        check("R2 any (10) fall", flags_o[0], 1'b1);
        check("R2 any fall value", capa_o[15:0], c);
        drive_pin(1, 1'b1, c);
        check("R2 any (11) rise", flags_o[1], 1'b1);
        clr_flags(3'b010);
        drive_pin(1, 1'b0, c);
        check("R2 any (11) fall", flags_o[1], 1'b1);
    endtask

    task automatic t_tie;
        logic [15:0] c;
        logic [15:0] cb;
        wr_cfg(0, mk(0, 0, 0, 1, 2'b00, 2'b01)); // tied, A rising, B falling
        clr_flags(3'b111);
        drive_pin(0, 1'b1, c);
        check("R4 tied A rise", capa_o[15:0], c);
        check("R4 tied B no flag on rise", flags_o[1], 1'b0);
        cb = capb_o[15:0];
        drive_pin(1, 1'b1, c);
        drive_pin(1, 1'b0, c);
        check("R4 pin B ignored flag", flags_o[1], 1'b0);
        check("R4 pin B ignored cap", capb_o[15:0], cb);
        drive_pin(0, 1'b0, c);
        check("R4 tied B falls from A", capb_o[15:0], c);
        check("R4 tied B flag", flags_o[1], 1'b1);
    endtask

    task automatic t_irq;
        check("R8 disabled irq low", irq_o[0], 1'b0);
        wr_ctl(4'b0100);
        check("R8 enabled irq high", irq_o[0], 1'b1);
        clr_flags(3'b001);
        check("R9 partial clear keeps B", flags_o[2:0], 3'b010);
        clr_flags(3'b010);
        check("R8 no flags irq low", irq_o[0], 1'b0);
        wr_ctl(4'b0000);
    endtask

    task automatic t_instep;
        wr_cfg(0, mk(0, 0, 0, 0, 0, 0));
        repeat (5) @(negedge clk);
        wr_ctl(4'b0001);
        check("R7 single restart", cnt_o[15:0] != cnt_o[31:16], 1);
        wr_ctl(4'b0011);
        check("R7 in step now", cnt_o[15:0], cnt_o[31:16]);
        repeat (9) @(negedge clk);
        check("R7 in step later", cnt_o[15:0], cnt_o[31:16]);
        check("R7 count after restart", cnt_o[31:16], 16'd9);
    endtask

    task automatic t_wrap;
        clr_flags(3'b111);
        wr_ctl(4'b0001);
        repeat (65535) @(negedge clk);
        check("R9 at all ones", cnt_o[15:0], 16'hFFFF);
        check("R9 no wrap yet", flags_o[2], 1'b0);
        @(negedge clk);
        check("R9 wrapped to zero", cnt_o[15:0], 16'd0);
        check("R9 wrap flag", flags_o[2], 1'b1);
    endtask

    task automatic t_slow;
        wr_cfg(0, mk(4'd15, 0, 0, 0, 0, 0));
        wr_ctl(4'b0001);
        repeat (32767) @(negedge clk);
        check("R1 div32768 before step", cnt_o[15:0], 16'd0);
        @(negedge clk);
        check("R1 div32768 step", cnt_o[15:0], 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_tout;
        t_presc;
        t_capture;
        t_any;
        t_tie;
        t_irq;
        t_instep;
        t_wrap;
        t_slow;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(150000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule